// File: doc/BRIEF.md
# Flash Unlock Command Sequence Decoder

This block sits behind the write side of a parallel NOR-style flash interface. It watches a stream of already-synchronised write strobes, each carrying an address and a data word. It recognises the multi-write unlock sequences that select an operation. Each recognised operation becomes a one-cycle request pulse for the program/erase engine or for the read logic. Each pulse comes with the full address of the write that completed it.

Every sequence opens with two unlock writes followed by a command write. Some commands complete there. Two setup commands open a second unlock pair and a final write that picks a chip erase, a sector erase, a sector lock or a sector unlock. The decoder also holds the read-path selection (array, identifier or status) that a read multiplexer elsewhere uses. While the engine reports busy, only status reads and abort get through.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After synchronous reset `req_o` is all zero, `req_addr` is zero and `read_sel` is 0 (array), with no command written.
- R2: A sequence is data AAh at address 5555h, then 55h at 2AAAh, then a command byte at 5555h. Only address bits [14:0] and data bits [7:0] are compared. The request pulse appears in the cycle after the strobe of the final write. The `req_o` bit positions are: 0 read-array, 1 identifier, 2 status read, 3 status clear, 4 page program, 5 chip erase, 6 sector erase, 7 sector lock, 8 sector unlock, 9 abort.
- R3: These third-write command bytes fire their request directly: F0h read-array, 90h identifier, A0h program, 70h status read, 50h status clear, E0h abort.
- R4: After setup byte 80h, a second AAh/5555h and 55h/2AAAh pair must follow. A final 10h at 5555h then requests chip erase, and a final 30h at any address requests sector erase.
- R5: After setup byte 60h, the same second pair must follow. A final 20h requests lock and a final 40h requests unlock, but only when address bits [19:15] are 00000b or 11111b. Any other sector value ends the sequence with no request.
- R6: A write that does not match the expected step sends the decoder back to idle. The same write is then tested as a first step (AAh at 5555h).
- R7: `busy_i` is sampled together with the write that would fire a request or enter a setup step. While it is high, only status read (70h) and abort (E0h) fire. Every other command, including the 80h and 60h setups, is dropped.
- R8: One cycle after a pulse, `read_sel` (0 array, 1 identifier, 2 status) is updated. Read-array sets 0 and identifier sets 1. Status read, program, both erases, lock, unlock and abort set 2. Status clear and the absence of a pulse leave it unchanged.
- R9: `req_addr` takes the full address of the final write together with the pulse and holds it until the next request.
- R10: `req_o` has at most one bit set and each request lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | One-cycle bus write strobe |
| wr_addr | input | 20 | Address of the bus write |
| wr_data | input | 16 | Data of the bus write |
| busy_i | input | 1 | Program/erase engine busy |
| req_o | output | 10 | One-hot request pulse (bit map in R2) |
| req_addr | output | 20 | Address latched with the last request |
| read_sel | output | 2 | Read-path selection (0 array, 1 identifier, 2 status) |

## Verification
The engine's busy flag can change in the very cycle the final write of a sequence arrives, so the filter and the step decode meet on the same edge. The bench changes `busy_i` on the edge of that final strobe in both directions. It rises on the last write of a sector erase, and falls on the last write of a sequence whose middle writes ran under busy. The request is judged only against the busy value sampled with the final write. A cycle-by-cycle behavioural model is compared on every clock, so a pulse that slips by a cycle or a read-path update on the wrong edge is caught.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
  localparam int NUM_REQ = 10;

  localparam int REQ_RDARR = 0;
  localparam int REQ_IDENT = 1;
  localparam int REQ_STAT  = 2;
  localparam int REQ_CLR   = 3;
  localparam int REQ_PROG  = 4;
  localparam int REQ_CHIP  = 5;
  localparam int REQ_SECT  = 6;
  localparam int REQ_LOCK  = 7;
  localparam int REQ_UNLK  = 8;
  localparam int REQ_ABORT = 9;

  localparam logic [NUM_REQ-1:0] BUSY_OK_MASK = 10'b10_0000_0100;
  localparam logic [NUM_REQ-1:0] TO_STATUS_MASK = 10'b11_1111_0100;

  localparam logic [7:0] CMD_RESET  = 8'hF0;
  localparam logic [7:0] CMD_IDENT  = 8'h90;
  localparam logic [7:0] CMD_PROG   = 8'hA0;
  localparam logic [7:0] CMD_STAT   = 8'h70;
  localparam logic [7:0] CMD_CLR    = 8'h50;
  localparam logic [7:0] CMD_ABORT  = 8'hE0;
  localparam logic [7:0] CMD_ESETUP = 8'h80;
  localparam logic [7:0] CMD_LSETUP = 8'h60;
  localparam logic [7:0] CMD_CHIP   = 8'h10;
  localparam logic [7:0] CMD_SECT   = 8'h30;
  localparam logic [7:0] CMD_LOCK   = 8'h20;
  localparam logic [7:0] CMD_UNLK   = 8'h40;

  localparam logic [7:0] KEY_LEAD   = 8'hAA;
  localparam logic [7:0] KEY_SECOND = 8'h55;

  typedef enum logic [1:0] {
    SEL_ARRAY  = 2'd0,
    SEL_IDENT  = 2'd1,
    SEL_STATUS = 2'd2
  } rsel_t;

  typedef enum logic [3:0] {
    ST_IDLE, ST_U1, ST_U2,
    ST_E0, ST_E1, ST_E2,
    ST_L0, ST_L1, ST_L2
  } step_t;
endpackage

// File: rtl/fcd_sequencer.sv
module fcd_sequencer
  import fcd_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int DATA_W  = 16,
  parameter int MATCH_W = 15,
  parameter int SECT_W  = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_stb,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               busy_i,
  output logic [NUM_REQ-1:0] req_o,
  output logic [ADDR_W-1:0]  req_addr
);
  localparam logic [MATCH_W-1:0] ADR_KEY  = MATCH_W'('h5555);
  localparam logic [MATCH_W-1:0] ADR_ALT  = MATCH_W'('h2AAA);

  step_t               step_q, step_d;
  logic [NUM_REQ-1:0]  fire;
  logic [7:0]          cmd;
  logic [MATCH_W-1:0]  low_addr;
  logic [SECT_W-1:0]   sect;
  logic                at_key, is_lead, is_second, sect_ok;
  logic                unused_hi;

  assign cmd       = wr_data[7:0];
  assign unused_hi = ^wr_data[DATA_W-1:8];
  assign low_addr  = wr_addr[MATCH_W-1:0];
  assign sect      = wr_addr[ADDR_W-1 -: SECT_W];
  assign at_key    = (low_addr == ADR_KEY);
  assign is_lead   = at_key && (cmd == KEY_LEAD);
  assign is_second = (low_addr == ADR_ALT) && (cmd == KEY_SECOND);
  assign sect_ok   = (&sect) || (sect == '0);

  always_comb begin
    step_d = step_q;
    fire   = '0;
    if (wr_stb) begin
      step_d = is_lead ? ST_U1 : ST_IDLE;
      case (step_q)
        ST_U1: if (is_second) step_d = ST_U2;
        ST_U2: begin
          if (at_key) begin
            case (cmd)
              CMD_RESET:  fire[REQ_RDARR] = !busy_i;
              CMD_IDENT:  fire[REQ_IDENT] = !busy_i;
              CMD_PROG:   fire[REQ_PROG]  = !busy_i;
              CMD_CLR:    fire[REQ_CLR]   = !busy_i;
              CMD_STAT:   fire[REQ_STAT]  = 1'b1;
              CMD_ABORT:  fire[REQ_ABORT] = 1'b1;
              CMD_ESETUP: if (!busy_i) step_d = ST_E0;
              CMD_LSETUP: if (!busy_i) step_d = ST_L0;
              default: ;
            endcase
          end
        end
        ST_E0: if (is_lead) step_d = ST_E1;
        ST_E1: if (is_second) step_d = ST_E2;
        ST_E2: begin
          if (!busy_i) begin
            if (cmd == CMD_CHIP && at_key) fire[REQ_CHIP] = 1'b1;
            else if (cmd == CMD_SECT)      fire[REQ_SECT] = 1'b1;
          end
        end
        ST_L0: if (is_lead) step_d = ST_L1;
        ST_L1: if (is_second) step_d = ST_L2;
        ST_L2: begin
          if (!busy_i && sect_ok) begin
            if (cmd == CMD_LOCK)      fire[REQ_LOCK] = 1'b1;
            else if (cmd == CMD_UNLK) fire[REQ_UNLK] = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q   <= ST_IDLE;
      req_o    <= '0;
      req_addr <= '0;
    end else begin
      step_q <= step_d;
      req_o  <= fire;
      if (|fire) req_addr <= wr_addr;
    end
  end

  // R10
  req_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(req_o));

  // R10
  req_needs_stb_chk: assert property (@(posedge clk) disable iff (rst)
    (|req_o) |-> $past(wr_stb));

  // R7
  busy_filter_chk: assert property (@(posedge clk) disable iff (rst)
    ((|req_o) && $past(busy_i)) |-> ((req_o & ~BUSY_OK_MASK) == '0));

  // R5
  lock_sector_chk: assert property (@(posedge clk) disable iff (rst)
    (req_o[REQ_LOCK] || req_o[REQ_UNLK]) |->
      ((&req_addr[ADDR_W-1 -: SECT_W]) || (req_addr[ADDR_W-1 -: SECT_W] == '0)));

  // R9
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(|req_o) |-> $stable(req_addr));
endmodule

// File: rtl/fcd_read_path.sv
module fcd_read_path
  import fcd_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_REQ-1:0] req_i,
  output logic [1:0]         read_sel
);
  rsel_t sel_q;

  always_ff @(posedge clk) begin
    if (rst)                            sel_q <= SEL_ARRAY;
    else if (req_i[REQ_RDARR])          sel_q <= SEL_ARRAY;
    else if (req_i[REQ_IDENT])          sel_q <= SEL_IDENT;
    else if (|(req_i & TO_STATUS_MASK)) sel_q <= SEL_STATUS;
  end

  assign read_sel = sel_q;

  // R1
  sel_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (read_sel == SEL_ARRAY));

  // R8
  sel_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(|req_i) |-> $stable(read_sel));

  // R8
  sel_prog_status_chk: assert property (@(posedge clk) disable iff (rst)
    $past(req_i[REQ_PROG]) |-> (read_sel == SEL_STATUS));
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int DATA_W  = 16,
  parameter int MATCH_W = 15,
  parameter int SECT_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              busy_i,
  output logic [9:0]        req_o,
  output logic [ADDR_W-1:0] req_addr,
  output logic [1:0]        read_sel
);
  logic [NUM_REQ-1:0] req_w;

  fcd_sequencer #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MATCH_W(MATCH_W), .SECT_W(SECT_W)
  ) u_seq (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_addr(wr_addr),
    .wr_data(wr_data), .busy_i(busy_i), .req_o(req_w), .req_addr(req_addr)
  );

  fcd_read_path u_rpath (
    .clk(clk), .rst(rst), .req_i(req_w), .read_sel(read_sel)
  );

  assign req_o = req_w;
endmodule

// File: tb/flash_cmd_decoder_bench.sv
module flash_cmd_decoder_bench;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_stb = 1'b0;
  logic [19:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        busy = 1'b0;
  logic [9:0]  req_o;
  logic [19:0] req_addr;
  logic [1:0]  read_sel;

  int    n_chk = 0;
  int    n_bad = 0;
  bit    done = 0;
  string cur_tag = "R1";

  // model state
  int          m_step = 0;
  bit          m_erase_fam = 0;
  logic [9:0]  m_req = '0;
  logic [19:0] m_addr = '0;
  logic [1:0]  m_sel = '0;

  always #(CLK_P/2) clk = ~clk;

  flash_cmd_decoder u_flash_cmd_decoder (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_addr(wr_addr),
    .wr_data(wr_data), .busy_i(busy), .req_o(req_o),
    .req_addr(req_addr), .read_sel(read_sel)
  );

  // behavioural reference
  always @(posedge clk) begin
    if (rst) begin
      m_step = 0; m_req = '0; m_addr = '0; m_sel = 2'd0;
    end else begin
      int nstep;
      bit lead, second, key5;
      logic [7:0] d;
      if (m_req[0]) m_sel = 2'd0;
      else if (m_req[1]) m_sel = 2'd1;
      else if ((m_req & 10'b11_1111_0100) != 0) m_sel = 2'd2;
      m_req = '0;
      if (wr_stb) begin
        d = wr_data[7:0];
        key5 = (wr_addr[14:0] == 15'h5555);
        lead = key5 && d == 8'hAA;
        second = (wr_addr[14:0] == 15'h2AAA) && d == 8'h55;
        nstep = lead ? 1 : 0;
        if (m_step == 1 && second) nstep = 2;
        else if (m_step == 2 && key5) begin
          if (d == 8'h70) m_req[2] = 1;
          else if (d == 8'hE0) m_req[9] = 1;
          else if (!busy) begin
            if (d == 8'hF0) m_req[0] = 1;
            if (d == 8'h90) m_req[1] = 1;
            if (d == 8'h50) m_req[3] = 1;
            if (d == 8'hA0) m_req[4] = 1;
            if (d == 8'h80) begin nstep = 3; m_erase_fam = 1; end
            if (d == 8'h60) begin nstep = 3; m_erase_fam = 0; end
          end
        end
        else if (m_step == 3 && lead) nstep = 4;
        else if (m_step == 4 && second) nstep = 5;
        else if (m_step == 5 && !busy) begin
          if (m_erase_fam) begin
            if (d == 8'h10 && key5) m_req[5] = 1;
            else if (d == 8'h30) m_req[6] = 1;
          end else if (wr_addr[19:15] == 5'b00000 || wr_addr[19:15] == 5'b11111) begin
            if (d == 8'h20) m_req[7] = 1;
            else if (d == 8'h40) m_req[8] = 1;
          end
        end
        if (m_req != 0) m_addr = wr_addr;
        m_step = nstep;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk({cur_tag, " model req_o"}, 32'(req_o), 32'(m_req));
      chk({cur_tag, " model req_addr"}, 32'(req_addr), 32'(m_addr));
      chk({cur_tag, " model read_sel"}, 32'(read_sel), 32'(m_sel));
    end
  end

  task automatic wr(input logic [19:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_stb = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic cmd3(input logic [7:0] c);
    wr(20'h05555, 16'h00AA);
    wr(20'h02AAA, 16'h0055);
    wr(20'h05555, {8'h00, c});
  endtask

  task automatic cmd6(input logic [7:0] setup, input logic [19:0] a, input logic [7:0] c);
    cmd3(setup);
    wr(20'h05555, 16'h00AA);
    wr(20'h02AAA, 16'h0055);
    wr(a, {8'h00, c});
  endtask

  task automatic finish_run();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_P * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    cur_tag = "R1";
    chk("R1 reset req_o", 32'(req_o), 0);
    chk("R1 reset req_addr", 32'(req_addr), 0);
    chk("R1 reset read_sel", 32'(read_sel), 0);

    cur_tag = "R3";
    cmd3(8'h70);
    chk("R3 status read pulse", 32'(req_o), 32'h004);
    chk("R9 status addr", 32'(req_addr), 32'h05555);
    @(negedge clk);
    chk("R8 status selects status", 32'(read_sel), 2);

    cur_tag = "R2";
    wr(20'hA5555, 16'h12AA);
    wr(20'h32AAA, 16'hFF55);
    wr(20'hC5555, 16'h77F0);
    chk("R2 upper bits ignored read-array", 32'(req_o), 32'h001);
    chk("R9 full address latched", 32'(req_addr), 32'hC5555);
    @(negedge clk);
    chk("R8 read-array selects array", 32'(read_sel), 0);

    cur_tag = "R3";
    cmd3(8'h90);
    chk("R3 identifier pulse", 32'(req_o), 32'h002);
    @(negedge clk);
    chk("R8 identifier selects ident", 32'(read_sel), 1);
    cmd3(8'h50);
    chk("R3 clear pulse", 32'(req_o), 32'h008);
    @(negedge clk);
    chk("R8 clear keeps selection", 32'(read_sel), 1);
    cmd3(8'hA0);
    chk("R3 program pulse", 32'(req_o), 32'h010);
    @(negedge clk);
    chk("R8 program selects status", 32'(read_sel), 2);

    cur_tag = "R4";
    cmd3(8'h90);
    cmd6(8'h80, 20'h05555, 8'h10);
    chk("R4 chip erase pulse", 32'(req_o), 32'h020);
    @(negedge clk);
    chk("R8 chip erase selects status", 32'(read_sel), 2);
    cmd6(8'h80, 20'h31234, 8'h30);
    chk("R4 sector erase pulse", 32'(req_o), 32'h040);
    chk("R9 sector address", 32'(req_addr), 32'h31234);
    @(negedge clk);
    chk("R10 pulse is one cycle", 32'(req_o), 0);
    chk("R9 address held", 32'(req_addr), 32'h31234);
    cmd6(8'h80, 20'h01234, 8'h10);
    chk("R4 chip erase needs 5555h", 32'(req_o), 0);

    cur_tag = "R5";
    cmd6(8'h60, 20'h00ABC, 8'h20);
    chk("R5 lock bottom sector", 32'(req_o), 32'h080);
    cmd6(8'h60, 20'hF8001, 8'h40);
    chk("R5 unlock top sector", 32'(req_o), 32'h100);
    cmd6(8'h60, 20'h08000, 8'h20);
    chk("R5 lock bad sector dropped", 32'(req_o), 0);
    chk("R5 address unchanged", 32'(req_addr), 32'hF8001);
    cmd6(8'h60, 20'h7FFFF, 8'h40);
    chk("R5 unlock bad sector dropped", 32'(req_o), 0);

    cur_tag = "R6";
    wr(20'h05555, 16'h00AA);
    cmd3(8'h70);
    chk("R6 repeated lead restarts", 32'(req_o), 32'h004);
    cmd3(8'h12);
    chk("R6 unknown command", 32'(req_o), 0);
    wr(20'h05555, 16'h00AA);
    wr(20'h02AAA, 16'h0056);
    wr(20'h05555, 16'h0070);
    chk("R6 bad second unlock", 32'(req_o), 0);
    wr(20'h05555, 16'h00AA);
    wr(20'h02AAA, 16'h0055);
    wr(20'h05554, 16'h0070);
    chk("R6 bad command address", 32'(req_o), 0);
    cmd3(8'h80);
    wr(20'h05555, 16'h00AA);
    wr(20'h02AAA, 16'h0054);
    wr(20'h05555, 16'h0010);
    chk("R6 bad inner unlock", 32'(req_o), 0);

    cur_tag = "R7";
    busy = 1'b1;
    cmd3(8'hF0);
    chk("R7 read-array blocked", 32'(req_o), 0);
    cmd3(8'h90);
    chk("R7 identifier blocked", 32'(req_o), 0);
    cmd3(8'h70);
    chk("R7 status allowed", 32'(req_o), 32'h004);
    cmd3(8'hE0);
    chk("R7 abort allowed", 32'(req_o), 32'h200);
    @(negedge clk);
    chk("R8 abort selects status", 32'(read_sel), 2);
    cmd6(8'h80, 20'h05555, 8'h10);
    chk("R7 erase setup blocked", 32'(req_o), 0);
    busy = 1'b0;
    cmd3(8'h80);
    wr(20'h05555, 16'h00AA);
    wr(20'h02AAA, 16'h0055);
    busy = 1'b1;
    wr(20'h12000, 16'h0030);
    chk("R7 busy rises on final write", 32'(req_o), 0);
    cmd3(8'h80);
    busy = 1'b0;
    cmd3(8'h80);
    busy = 1'b1;
    wr(20'h05555, 16'h00AA);
    wr(20'h02AAA, 16'h0055);
    busy = 1'b0;
    wr(20'h12000, 16'h0030);
    chk("R7 busy falls on final write", 32'(req_o), 32'h040);

    cur_tag = "R10";
    repeat (3) @(negedge clk);
    chk("R10 quiet bus no request", 32'(req_o), 0);
    finish_run();
  end
endmodule